// File: doc/BRIEF.md
# Three-Wire Serial Configuration Slave

This block receives configuration from a microcontroller over three lines: a control clock, a framing line and a data line. Bits are taken on each rising edge of the control clock, most significant bit first, and grouped into bytes. The framing line tells the block what kind of byte is arriving.

While the framing line is low, each byte is an address byte. It carries a six-bit device identity and a two-bit group selector. While the framing line is high, each byte is a data byte. A data byte only takes effect if the last address byte matched this device and picked a group that exists. Its two top bits then choose one register inside that group.

All three lines are brought into the system clock domain through synchronizers and turned into edge events there. The decoded fields leave the block as plain, always-valid configuration pins. They carry no handshake, because nothing downstream can stall them.

Top module: `s3c_slave`

## Requirements
- R1: A register changes only after eight bits have been taken on rising control-clock edges, most significant bit first. A partial byte changes nothing.
- R2: An address byte (framing low) selects the device when bits 7:2 equal 000101. Bits 1:0 of that byte become the active group.
- R3: An address byte with any other value in bits 7:2 deselects the device. Every data byte that follows is then ignored until a matching address byte arrives.
- R4: The selection and the group made by an address byte stay in force over any number of data bytes.
- R5: In group 10, a data byte whose bits 7:6 are 00 loads `clk_sel` from bits 5:4 and `fmt_sel` from bits 3:1. Data bytes in group 10 with bits 7:6 equal to 01, 10 or 11 are ignored. For `clk_sel`, 00 means 512fs, 01 means 384fs and 10 means 256fs.
- R6: In group 00, a data byte whose bits 7:6 are 00 loads `vol_code` from bits 5:0.
- R7: In group 00, a data byte whose bits 7:6 are 10 loads `deemph_sel` from bits 4:3 and `mute_on` from bit 2. Data bytes in group 00 with bits 7:6 equal to 01 or 11 are ignored. For `deemph_sel`, 00 means off, 01 means 32 kHz, 10 means 44.1 kHz and 11 means 48 kHz.
- R8: When the active group is 01 or 11, data bytes are ignored.
- R9: Any change on the framing line discards the bits gathered so far. The next byte starts fresh.
- R10: After reset, every output field is zero and the device is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_clk | input | 1 | Serial control clock; data is taken on its rising edge |
| ctl_mode | input | 1 | Framing line: low for address bytes, high for data bytes |
| ctl_dat | input | 1 | Serial data, most significant bit first |
| clk_sel | output | 2 | System clock ratio code |
| fmt_sel | output | 3 | Input format code |
| vol_code | output | 6 | Attenuation code in 1 dB steps |
| deemph_sel | output | 2 | De-emphasis code |
| mute_on | output | 1 | Mute enable |

## Verification
All 64 device identities are swept, each one followed by a volume byte. This shows that exactly one identity opens the device and that a foreign one closes it again. All 64 volume codes, every de-emphasis and mute pair, and all 32 clock and format pairs are written. This proves that each bit lands in its own field. Data bytes are also sent in the two unused groups and with unused sub-selectors, and bytes are cut short by a change on the framing line. Each of these should leave every field unchanged, or it should carry only the complete byte that follows.

// File: rtl/s3c_pkg.sv
package s3c_pkg;
  typedef enum logic [1:0] {
    GRP_DATA   = 2'b00,
    GRP_SPARE1 = 2'b01,
    GRP_STATUS = 2'b10,
    GRP_SPARE3 = 2'b11
  } grp_e;

  localparam logic [1:0] SUB_LOW  = 2'b00;
  localparam logic [1:0] SUB_HIGH = 2'b10;

  typedef struct packed {
    logic [1:0] clk_sel;
    logic [2:0] fmt;
    logic [5:0] vol;
    logic [1:0] deemph;
    logic       mute;
  } cfg_t;
endpackage

// File: rtl/s3c_sync.sv
module s3c_sync #(
  parameter int N_LINES = 3,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] din,
  output logic [N_LINES-1:0] level,
  output logic [N_LINES-1:0] rise,
  output logic [N_LINES-1:0] toggle
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din[g]};
    end
    assign level[g]  = chain[STAGES-1];
    assign rise[g]   = chain[STAGES-1] & ~chain[STAGES];
    assign toggle[g] = chain[STAGES-1] ^ chain[STAGES];
  end
endmodule

// File: rtl/s3c_shift.sv
module s3c_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_rise,
  input  logic              bit_val,
  input  logic              frame_flip,
  input  logic              mode_lvl,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q,
  output logic              byte_mode
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] nxt;

  assign nxt = {sh[BYTE_W-2:0], bit_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      sh        <= '0;
      byte_vld  <= 1'b0;
      byte_q    <= '0;
      byte_mode <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (frame_flip) begin
        cnt <= '0;
      end else if (bit_rise) begin
        sh <= nxt;
        if (cnt == LAST) begin
          cnt       <= '0;
          byte_vld  <= 1'b1;
          byte_q    <= nxt;
          byte_mode <= mode_lvl;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R9: a framing change restarts the bit count
  p_mode_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_flip |=> cnt == '0);
  // R1: a byte is emitted only on the eighth sampled bit
  p_full_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> ($past(bit_rise) && !$past(frame_flip) && $past(cnt) == LAST));
endmodule

// File: rtl/s3c_regs.sv
module s3c_regs
  import s3c_pkg::*;
#(
  parameter int              ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 6'b000101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [ADDR_W+1:0] byte_q,
  input  logic              byte_mode,
  output cfg_t              cfg
);
  localparam int BW = ADDR_W + 2;

  logic       sel_q;
  grp_e       grp_q;
  cfg_t       cfg_q;
  logic [1:0] sub;

  assign sub = byte_q[BW-1:BW-2];
  assign cfg = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      grp_q <= GRP_DATA;
      cfg_q <= '0;
    end else if (byte_vld) begin
      if (!byte_mode) begin
        sel_q <= (byte_q[BW-1:2] == DEV_ADDR);
        grp_q <= grp_e'(byte_q[1:0]);
      end else if (sel_q) begin
        case (grp_q)
          GRP_DATA: begin
            if (sub == SUB_LOW) begin
              cfg_q.vol <= byte_q[5:0];
            end else if (sub == SUB_HIGH) begin
              cfg_q.deemph <= byte_q[4:3];
              cfg_q.mute   <= byte_q[2];
            end
          end
          GRP_STATUS: begin
            if (sub == SUB_LOW) begin
              cfg_q.clk_sel <= byte_q[5:4];
              cfg_q.fmt     <= byte_q[3:1];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: matching address selects and latches the group
  p_addr_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !byte_mode && byte_q[BW-1:2] == DEV_ADDR)
      |=> (sel_q && grp_q == $past(byte_q[1:0])));
  // R3: deselected device ignores data bytes
  p_foreign_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_mode && !sel_q) |=> $stable(cfg_q));
  // R4: data bytes never alter the selection
  p_keep_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_mode) |=> ($stable(sel_q) && $stable(grp_q)));
  // R8: unused groups change nothing
  p_spare_grp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_mode && grp_q[0]) |=> $stable(cfg_q));
  // R1: fields move only on a completed byte
  p_only_on_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(cfg_q));
endmodule

// File: rtl/s3c_slave.sv
module s3c_slave
  import s3c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [5:0] DEV_ADDR = 6'b000101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_clk,
  input  logic       ctl_mode,
  input  logic       ctl_dat,
  output logic [1:0] clk_sel,
  output logic [2:0] fmt_sel,
  output logic [5:0] vol_code,
  output logic [1:0] deemph_sel,
  output logic       mute_on
);
  localparam int ADDR_W = 6;
  localparam int BYTE_W = ADDR_W + 2;

  logic [2:0] lvl, rise, flip;
  logic              byte_vld, byte_mode;
  logic [BYTE_W-1:0] byte_q;
  cfg_t              cfg;

  s3c_sync #(.N_LINES(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({ctl_dat, ctl_mode, ctl_clk}),
    .level(lvl), .rise(rise), .toggle(flip)
  );

  s3c_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .bit_rise(rise[0]), .bit_val(lvl[2]),
    .frame_flip(flip[1]), .mode_lvl(lvl[1]),
    .byte_vld(byte_vld), .byte_q(byte_q), .byte_mode(byte_mode)
  );

  s3c_regs #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .byte_vld(byte_vld), .byte_q(byte_q), .byte_mode(byte_mode),
    .cfg(cfg)
  );

  assign clk_sel    = cfg.clk_sel;
  assign fmt_sel    = cfg.fmt;
  assign vol_code   = cfg.vol;
  assign deemph_sel = cfg.deemph;
  assign mute_on    = cfg.mute;
endmodule

// File: tb/tb_s3c_slave.sv
module tb_s3c_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_clk = 1'b0, ctl_mode = 1'b0, ctl_dat = 1'b0;
  logic [1:0] clk_sel, deemph_sel;
  logic [2:0] fmt_sel;
  logic [5:0] vol_code;
  logic       mute_on;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic       e_sel;
  logic [1:0] e_grp, e_clk, e_de;
  logic [2:0] e_fmt;
  logic [5:0] e_vol;
  logic       e_mute;

  always #5 clk = ~clk;

  s3c_slave dut (
    .clk(clk), .rst_n(rst_n), .ctl_clk(ctl_clk), .ctl_mode(ctl_mode),
    .ctl_dat(ctl_dat), .clk_sel(clk_sel), .fmt_sel(fmt_sel),
    .vol_code(vol_code), .deemph_sel(deemph_sel), .mute_on(mute_on)
  );

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic check(string req);
    @(negedge clk);
    checks++;
    if ({clk_sel, fmt_sel, vol_code, deemph_sel, mute_on} !==
        {e_clk, e_fmt, e_vol, e_de, e_mute}) begin
      errors++;
      $display("FAIL %s actual clk=%0d fmt=%0d vol=%0d de=%0d mute=%0d expected clk=%0d fmt=%0d vol=%0d de=%0d mute=%0d",
               req, clk_sel, fmt_sel, vol_code, deemph_sel, mute_on,
               e_clk, e_fmt, e_vol, e_de, e_mute);
    end
  endtask

  task automatic set_mode(logic m);
    @(negedge clk);
    ctl_mode = m;
    wait_clk(6);
  endtask

  task automatic send_bits(logic [7:0] v, int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk);
      ctl_dat = v[i];
      wait_clk(4);
      @(negedge clk);
      ctl_clk = 1'b1;
      wait_clk(4);
      @(negedge clk);
      ctl_clk = 1'b0;
    end
    wait_clk(8);
  endtask

  // bench model of the decode
  task automatic model(logic m, logic [7:0] b);
    if (!m) begin
      e_sel = (b[7:2] == 6'b000101);
      e_grp = b[1:0];
    end else if (e_sel) begin
      if (e_grp == 2'b00 && b[7:6] == 2'b00) e_vol = b[5:0];
      else if (e_grp == 2'b00 && b[7:6] == 2'b10) begin
        e_de = b[4:3]; e_mute = b[2];
      end else if (e_grp == 2'b10 && b[7:6] == 2'b00) begin
        e_clk = b[5:4]; e_fmt = b[3:1];
      end
    end
  endtask

  task automatic send_byte(logic m, logic [7:0] b);
    set_mode(m);
    send_bits(b, 8);
    model(m, b);
  endtask

  initial begin
    e_sel = 0; e_grp = 0; e_clk = 0; e_de = 0; e_fmt = 0; e_vol = 0; e_mute = 0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    check("R10 reset state");

    // R2/R3: sweep every identity, followed by a volume byte
    for (int a = 0; a < 64; a++) begin
      send_byte(1'b0, {a[5:0], 2'b00});
      send_byte(1'b1, {2'b00, 6'(a ^ 6'h2a)});
      check(a == 5 ? "R2 matching address" : "R3 foreign address ignored");
    end

    // R6/R4: all volume codes under one address
    send_byte(1'b0, 8'b000101_00);
    for (int v = 0; v < 64; v++) begin
      send_byte(1'b1, {2'b00, v[5:0]});
      check("R6 R4 volume code");
    end
    // R7: de-emphasis and mute pairs, plus ignored sub-selectors
    for (int d = 0; d < 8; d++) begin
      send_byte(1'b1, {2'b10, 1'b0, d[2:1], d[0], 2'b00});
      check("R7 de-emphasis and mute");
    end
    send_byte(1'b1, 8'b01_111111);
    check("R7 sub 01 ignored");
    send_byte(1'b1, 8'b11_111111);
    check("R7 sub 11 ignored");

    // R5: status group, all clock and format pairs
    send_byte(1'b0, 8'b000101_10);
    for (int s = 0; s < 32; s++) begin
      send_byte(1'b1, {2'b00, s[4:3], s[2:0], 1'b1});
      check("R5 clock and format");
    end
    send_byte(1'b1, 8'b10_010100);
    check("R5 status sub 10 ignored");

    // R8: unused groups
    send_byte(1'b0, 8'b000101_01);
    send_byte(1'b1, 8'b00_110011);
    check("R8 group 01 ignored");
    send_byte(1'b0, 8'b000101_11);
    send_byte(1'b1, 8'b00_001100);
    check("R8 group 11 ignored");

    // R1: partial data byte then framing change changes nothing
    send_byte(1'b0, 8'b000101_00);
    set_mode(1'b1);
    send_bits(8'b00_111111, 5);
    set_mode(1'b0);
    check("R1 partial byte no update");
    // R9: partial address bits discarded, clean byte follows
    send_bits(8'b111111_11, 3);
    send_byte(1'b1, 8'b00_100110);
    check("R9 partial bits dropped");
    set_mode(1'b0);
    send_bits(8'b000101_00, 8);
    model(1'b0, 8'b000101_00);
    set_mode(1'b1);
    send_bits(8'b00_000000, 6);
    set_mode(1'b0);
    set_mode(1'b1);
    send_bits(8'b00_011001, 8);
    model(1'b1, 8'b00_011001);
    check("R9 restart after flip");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule